// File: doc/BRIEF.md
# CAM Host Bus Access Controller

This block sits between a 16-bit host bus and the registers of a content-addressable memory. Every clock in which the active-low enable is low is one bus cycle. The command/data and write strobes sort that cycle into one of four kinds: command write, command read, data write or data read. The block then sends the cycle to the register or array port it addresses. Routing follows three rules. A command cycle goes to a default target. A one-shot override, armed by an instruction, replaces that default for exactly one later command cycle. Data cycles go to a persistent source or destination that stays until another selection instruction changes it.

The block also does three more jobs. It alternates between the low and high halves of a 32-bit status word on back-to-back command reads. It steps a segment counter so that 64-bit resources are reached one 16-bit word at a time. It decides whether the device answers a cycle at all, by comparing a device-select register with a page register, with one code reserved for write-only broadcast. The match logic and the priority encoder are outside the block: status, the next-free address and the highest-priority match address arrive as plain inputs. The comparand register, the two mask registers and a small word array are kept as simple storage.

The data bus is split into an input, an output and a drive enable. An instruction word carries its opcode in bits 15:12, its address-field flag in bit 11 and its operand code in bits 2:0.

Top module: `camHostAccess`

## Requirements
- R1: With `enN` high, `dataOe` stays low and no register changes. `dataOe` is high only in a selected read cycle. Cycle kinds, as (`cmN`,`wN`): command write is (0,0), command read is (0,1), data write is (1,0) and data read is (1,1).
- R2: A selected command write with no override and no address flag pending is taken as an instruction. Opcode 4'h1 arms an override. Opcode 4'h2 selects the persistent source. Opcode 4'h3 selects the persistent destination. Opcode 4'h0 does nothing.
- R3: If the instruction taken in the previous clock had bit 11 set, a command write in the current clock loads the address register rather than the decoder. Any other cycle in between, idle included, cancels this.
- R4: An override instruction names a target in bits 2:0: 0 address, 1 control, 2 page, 3 segment control, 4 device select, 5 next-free address, 6 source selection, 7 destination selection. Only the next selected command cycle, read or write, goes to that target. Data and idle cycles before it leave the override pending.
- R5: A read through override target 5 returns the next-free address input, zero-extended. A write through target 5 changes nothing.
- R6: A selected command read with no override returns status bits 15:0 and the next one returns bits 31:16, alternating. Any cycle that is not a selected command read makes the next one return bits 15:0.
- R7: After reset, both the persistent source and the persistent destination are the comparand. Source codes are: 0 comparand, 1 mask 1, 2 mask 2, 3 array at the address register, 4 array at the match address. Destination codes 0 to 3 are the same, 4 is array at the next-free address and 5 is array at the match address. Codes outside these ranges leave the selection unchanged.
- R8: The device is selected when device select equals page. It is also selected for writes only when device select is 16'hFFFF. A device-select override instruction and the device-select write that follows it are always accepted. Deselected cycles change nothing and leave `dataOe` low.
- R9: A read through target 6 or 7 returns the whole instruction word that last set the source or the destination. These words reset to 16'h2000 and 16'h3000.
- R10: Data cycles address word `segIdx` of the 64-bit resource, where bits 1:0 of segment control give the start and bits 3:2 give the end. Each selected data cycle steps the index, and after the end it goes back to the start. The index returns to the start when a source or destination is selected, and when segment control is loaded (to the new start). Segment control resets to 16'h000C.
- R11: A data write to array destinations stores the word in the entry chosen by the address register, the next-free address or the match address. Array source reads return the word from the entry chosen in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enN | input | 1 | Active-low cycle enable |
| cmN | input | 1 | Low for command cycles, high for data cycles |
| wN | input | 1 | Low for writes, high for reads |
| dataIn | input | 16 | Bus write data |
| dataOut | output | 16 | Bus read data, zero when not driven |
| dataOe | output | 1 | Bus drive enable |
| statusIn | input | 32 | Status word from match logic |
| freeAddr | input | 4 | Next-free array entry |
| matchAddr | input | 4 | Highest-priority match entry |

## Verification
The routing is exercised with several mixes of cycles. Back-to-back command reads, and command reads broken up by idle or data cycles, show whether the status half alternates or resets. Override instructions followed by data cycles, and address-flag instructions followed by idle cycles, show whether one-shot routing lasts exactly as long as it should. Segment sequences are run with the default window and with a narrowed window, across source and destination changes. The device is then taken through broadcast mode, through full deselection and back, and writes made while deselected are read back afterwards. This shows the difference between ignored cycles and write-only cycles.

// File: rtl/camHostPkg.sv
package camHostPkg;

  localparam logic [3:0] OP_NOP = 4'h0;
  localparam logic [3:0] OP_TCO = 4'h1;
  localparam logic [3:0] OP_SRC = 4'h2;
  localparam logic [3:0] OP_DST = 4'h3;

  // target of a one-shot override
  typedef enum logic [2:0] {
    TGT_ADDR, TGT_CTRL, TGT_PAGE, TGT_SEG,
    TGT_DEVSEL, TGT_NFA, TGT_PSRC, TGT_PDST
  } tgtT;

  // persistent data resource
  typedef enum logic [2:0] {
    RES_COMP, RES_MASK1, RES_MASK2, RES_ARR_ADDR, RES_ARR_FREE, RES_ARR_MATCH
  } resT;

  // read data selection
  typedef enum logic [3:0] {
    RD_NONE, RD_STAT_LO, RD_STAT_HI, RD_ADDR, RD_CTRL, RD_PAGE,
    RD_SEG, RD_DEVSEL, RD_NFA, RD_PSRC, RD_PDST, RD_RES
  } rdT;

  typedef struct packed {
    logic ldAddr;
    logic ldCtrl;
    logic ldPage;
    logic ldSeg;
    logic ldDevSel;
    logic ldSrcWord;
    logic ldDstWord;
    logic wrRes;
    logic segStep;
    logic segRestart;
    resT  res;
    rdT   rd;
  } strobeT;

endpackage

// File: rtl/camSegCounter.sv
module camSegCounter #(
  parameter int SEG_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  input  logic             restart,
  input  logic             load,
  input  logic [SEG_W-1:0] loadStart,
  input  logic [SEG_W-1:0] startIdx,
  input  logic [SEG_W-1:0] endIdx,
  output logic [SEG_W-1:0] idx
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx <= '0;
    end else if (load) begin
      idx <= loadStart;
    end else if (restart) begin
      idx <= startIdx;
    end else if (step) begin
      idx <= (idx == endIdx) ? startIdx : idx + 1'b1;
    end
  end

endmodule

// File: rtl/camHostCtl.sv
module camHostCtl
  import camHostPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enN,
  input  logic              cmN,
  input  logic              wN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              pageMatch,
  input  logic              devAll,
  output strobeT            stb,
  output logic              dataOe,
  output logic              overridePend,
  output logic              statusHigh
);

  tgtT  ovTgt, ovTgtNext;
  resT  srcSel, srcNext, dstSel, dstNext;
  logic addrPend, addrPendNext, ovPendNext, statHiNext;
  logic isCmd, isData, isWr, tcoDevInstr, devPath, selected;
  logic [3:0] opCode;
  logic [2:0] operand;

  assign opCode  = dataIn[15:12];
  assign operand = dataIn[2:0];
  assign isCmd   = !enN && !cmN;
  assign isData  = !enN && cmN;
  assign isWr    = !wN;

  // the device-select path stays reachable while deselected
  assign tcoDevInstr = isCmd && isWr && !overridePend && !addrPend &&
                       opCode == OP_TCO && operand == 3'd4;
  assign devPath  = isCmd && isWr &&
                    ((overridePend && ovTgt == TGT_DEVSEL) || tcoDevInstr);
  assign selected = !enN && (pageMatch || (devAll && isWr) || devPath);
  assign dataOe   = selected && !isWr;

  function automatic resT srcCode(input logic [2:0] c);
    return (c == 3'd4) ? RES_ARR_MATCH : resT'(c);
  endfunction

  always_comb begin
    stb          = '0;
    ovPendNext   = overridePend;
    ovTgtNext    = ovTgt;
    addrPendNext = 1'b0;
    statHiNext   = 1'b0;
    srcNext      = srcSel;
    dstNext      = dstSel;

    if (selected && isCmd && isWr) begin
      if (overridePend) begin
        ovPendNext = 1'b0;
        case (ovTgt)
          TGT_ADDR:   stb.ldAddr   = 1'b1;
          TGT_CTRL:   stb.ldCtrl   = 1'b1;
          TGT_PAGE:   stb.ldPage   = 1'b1;
          TGT_SEG:    stb.ldSeg    = 1'b1;
          TGT_DEVSEL: stb.ldDevSel = 1'b1;
          default:    ;
        endcase
      end else if (addrPend) begin
        stb.ldAddr = 1'b1;
      end else begin
        addrPendNext = dataIn[11];
        case (opCode)
          OP_TCO: begin
            ovPendNext = 1'b1;
            ovTgtNext  = tgtT'(operand);
          end
          OP_SRC: begin
            if (operand <= 3'd4) begin
              srcNext        = srcCode(operand);
              stb.ldSrcWord  = 1'b1;
              stb.segRestart = 1'b1;
            end
          end
          OP_DST: begin
            if (operand <= 3'd5) begin
              dstNext        = resT'(operand);
              stb.ldDstWord  = 1'b1;
              stb.segRestart = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end

    if (selected && isCmd && !isWr) begin
      if (overridePend) begin
        ovPendNext = 1'b0;
        case (ovTgt)
          TGT_ADDR:   stb.rd = RD_ADDR;
          TGT_CTRL:   stb.rd = RD_CTRL;
          TGT_PAGE:   stb.rd = RD_PAGE;
          TGT_SEG:    stb.rd = RD_SEG;
          TGT_DEVSEL: stb.rd = RD_DEVSEL;
          TGT_NFA:    stb.rd = RD_NFA;
          TGT_PSRC:   stb.rd = RD_PSRC;
          default:    stb.rd = RD_PDST;
        endcase
      end else begin
        stb.rd     = statusHigh ? RD_STAT_HI : RD_STAT_LO;
        statHiNext = !statusHigh;
      end
    end

    if (selected && isData) begin
      stb.segStep = 1'b1;
      stb.wrRes   = isWr;
      stb.res     = isWr ? dstSel : srcSel;
      stb.rd      = isWr ? RD_NONE : RD_RES;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overridePend <= 1'b0;
      ovTgt        <= TGT_ADDR;
      addrPend     <= 1'b0;
      statusHigh   <= 1'b0;
      srcSel       <= RES_COMP;
      dstSel       <= RES_COMP;
    end else begin
      overridePend <= ovPendNext;
      ovTgt        <= ovTgtNext;
      addrPend     <= addrPendNext;
      statusHigh   <= statHiNext;
      srcSel       <= srcNext;
      dstSel       <= dstNext;
    end
  end

endmodule

// File: rtl/camHostDp.sv
module camHostDp
  import camHostPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORD_W = 64,
  parameter int DEPTH  = 16,
  localparam int SEGS   = WORD_W / DATA_W,
  localparam int SEG_W  = $clog2(SEGS),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              stb,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [2*DATA_W-1:0] statusIn,
  input  logic [ADDR_W-1:0]   freeAddr,
  input  logic [ADDR_W-1:0]   matchAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic                pageMatch,
  output logic                devAll,
  output logic [SEG_W-1:0]    segIdx
);

  typedef logic [SEGS-1:0][DATA_W-1:0] wordT;

  localparam logic [DATA_W-1:0] SEG_RESET = DATA_W'((SEGS - 1) << SEG_W);

  logic [DATA_W-1:0] addrReg, ctrlReg, pageReg, segReg, devSelReg;
  logic [DATA_W-1:0] srcWord, dstWord;
  wordT compReg, mask1Reg, mask2Reg;
  wordT mem [DEPTH];
  logic [ADDR_W-1:0] addrIdx, resIdx;

  assign addrIdx   = addrReg[ADDR_W-1:0];
  assign pageMatch = devSelReg == pageReg;
  assign devAll    = &devSelReg;

  camSegCounter #(.SEG_W(SEG_W)) segCnt (
    .clk      (clk),
    .rstN     (rstN),
    .step     (stb.segStep),
    .restart  (stb.segRestart),
    .load     (stb.ldSeg),
    .loadStart(dataIn[SEG_W-1:0]),
    .startIdx (segReg[SEG_W-1:0]),
    .endIdx   (segReg[2*SEG_W-1:SEG_W]),
    .idx      (segIdx)
  );

  // entry used by array resources
  always_comb begin
    case (stb.res)
      RES_ARR_FREE:  resIdx = freeAddr;
      RES_ARR_MATCH: resIdx = matchAddr;
      default:       resIdx = addrIdx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      ctrlReg   <= '0;
      pageReg   <= '0;
      segReg    <= SEG_RESET;
      devSelReg <= '0;
      srcWord   <= {OP_SRC, {(DATA_W-4){1'b0}}};
      dstWord   <= {OP_DST, {(DATA_W-4){1'b0}}};
    end else begin
      if (stb.ldAddr)    addrReg   <= dataIn;
      if (stb.ldCtrl)    ctrlReg   <= dataIn;
      if (stb.ldPage)    pageReg   <= dataIn;
      if (stb.ldSeg)     segReg    <= dataIn;
      if (stb.ldDevSel)  devSelReg <= dataIn;
      if (stb.ldSrcWord) srcWord   <= dataIn;
      if (stb.ldDstWord) dstWord   <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      compReg  <= '0;
      mask1Reg <= '0;
      mask2Reg <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb.wrRes) begin
      case (stb.res)
        RES_COMP:  compReg[segIdx]  <= dataIn;
        RES_MASK1: mask1Reg[segIdx] <= dataIn;
        RES_MASK2: mask2Reg[segIdx] <= dataIn;
        default:   mem[resIdx][segIdx] <= dataIn;
      endcase
    end
  end

  always_comb begin
    case (stb.rd)
      RD_STAT_LO: rdData = statusIn[DATA_W-1:0];
      RD_STAT_HI: rdData = statusIn[2*DATA_W-1:DATA_W];
      RD_ADDR:    rdData = addrReg;
      RD_CTRL:    rdData = ctrlReg;
      RD_PAGE:    rdData = pageReg;
      RD_SEG:     rdData = segReg;
      RD_DEVSEL:  rdData = devSelReg;
      RD_NFA:     rdData = DATA_W'(freeAddr);
      RD_PSRC:    rdData = srcWord;
      RD_PDST:    rdData = dstWord;
      RD_RES: begin
        case (stb.res)
          RES_COMP:  rdData = compReg[segIdx];
          RES_MASK1: rdData = mask1Reg[segIdx];
          RES_MASK2: rdData = mask2Reg[segIdx];
          default:   rdData = mem[resIdx][segIdx];
        endcase
      end
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/camHostAccess.sv
module camHostAccess
  import camHostPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORD_W = 64,
  parameter int DEPTH  = 16,
  localparam int SEG_W  = $clog2(WORD_W / DATA_W),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enN,
  input  logic                cmN,
  input  logic                wN,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOe,
  input  logic [2*DATA_W-1:0] statusIn,
  input  logic [ADDR_W-1:0]   freeAddr,
  input  logic [ADDR_W-1:0]   matchAddr
);

  strobeT            stb;
  logic              pageMatch, devAll, overridePend, statusHigh;
  logic [SEG_W-1:0]  segIdx;
  logic [DATA_W-1:0] rdData;

  camHostCtl #(.DATA_W(DATA_W)) ctl (
    .clk         (clk),
    .rstN        (rstN),
    .enN         (enN),
    .cmN         (cmN),
    .wN          (wN),
    .dataIn      (dataIn),
    .pageMatch   (pageMatch),
    .devAll      (devAll),
    .stb         (stb),
    .dataOe      (dataOe),
    .overridePend(overridePend),
    .statusHigh  (statusHigh)
  );

  camHostDp #(.DATA_W(DATA_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .dataIn   (dataIn),
    .statusIn (statusIn),
    .freeAddr (freeAddr),
    .matchAddr(matchAddr),
    .rdData   (rdData),
    .pageMatch(pageMatch),
    .devAll   (devAll),
    .segIdx   (segIdx)
  );

  assign dataOut = dataOe ? rdData : '0;

endmodule

// File: rtl/camHostChk.sv
module camHostChk #(
  parameter int SEG_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             enN,
  input logic             cmN,
  input logic             wN,
  input logic             dataOe,
  input logic             overridePend,
  input logic             statusHigh,
  input logic             pageMatch,
  input logic [SEG_W-1:0] segIdx
);

  // R1
  idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    enN |-> !dataOe);

  // R1
  drive_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (!enN && wN));

  // R4
  override_expire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overridePend && !enN && !cmN && pageMatch) |=> !overridePend);

  // R6
  status_alternate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!overridePend && !enN && !cmN && wN && pageMatch && !statusHigh) |=> statusHigh);

  // R6
  status_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!enN && !cmN && wN) |=> !statusHigh);

  // R8
  deselect_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> pageMatch);

  // R10
  seg_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    enN |=> $stable(segIdx));

endmodule

bind camHostAccess camHostChk #(.SEG_W(SEG_W)) chk (.*);

// File: tb/camHostAccess_test.sv
`timescale 1ns/1ps
module camHostAccess_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enN = 1'b1, cmN = 1'b1, wN = 1'b1;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic        dataOe;
  logic [31:0] statusIn = 32'hBEEF_1234;
  logic [3:0]  freeAddr = 4'd9;
  logic [3:0]  matchAddr = 4'd5;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  camHostAccess uut (
    .clk(clk), .rstN(rstN), .enN(enN), .cmN(cmN), .wN(wN),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .statusIn(statusIn), .freeAddr(freeAddr), .matchAddr(matchAddr)
  );

  // behavioural reference state
  logic [15:0] mAddr, mCtrl, mPage, mSeg, mDevSel, mSrcWord, mDstWord;
  logic [15:0] mComp [4];
  logic [15:0] mM1 [4];
  logic [15:0] mM2 [4];
  logic [15:0] mArr [16][4];
  int mSrc, mDst, mTgt, mSegIdx;
  bit mOvPend, mAddrPend, mStatHi;

  task automatic modelReset();
    mAddr = 0; mCtrl = 0; mPage = 0; mSeg = 16'h000C; mDevSel = 0;
    mSrcWord = 16'h2000; mDstWord = 16'h3000;
    for (int i = 0; i < 4; i++) begin
      mComp[i] = 0; mM1[i] = 0; mM2[i] = 0;
      for (int j = 0; j < 16; j++) mArr[j][i] = 0;
    end
    mSrc = 0; mDst = 0; mTgt = 0; mSegIdx = 0;
    mOvPend = 0; mAddrPend = 0; mStatHi = 0;
  endtask

  task automatic modelCycle(input bit en, input bit cm, input bit w, input logic [15:0] d,
                            output bit expOe, output logic [15:0] expData);
    int op = d[15:12];
    int code = d[2:0];
    bit isCmd = !en && !cm;
    bit isData = !en && cm;
    bit isWr = !w;
    bit devPath, sel, nextAddrPend, nextStatHi;
    int segStart = mSeg[1:0];
    int segEnd = mSeg[3:2];
    int kind, entry;
    devPath = isCmd && isWr && ((mOvPend && mTgt == 4) ||
              (!mOvPend && !mAddrPend && op == 1 && code == 4));
    sel = !en && (mPage == mDevSel || (mDevSel == 16'hFFFF && isWr) || devPath);
    expOe = sel && !isWr;
    expData = 0;
    nextAddrPend = 0;
    nextStatHi = 0;
    if (sel && isCmd && isWr) begin
      if (mOvPend) begin
        mOvPend = 0;
        case (mTgt)
          0: mAddr = d;
          1: mCtrl = d;
          2: mPage = d;
          3: begin mSeg = d; mSegIdx = d[1:0]; end
          4: mDevSel = d;
          default: ;
        endcase
      end else if (mAddrPend) begin
        mAddr = d;
      end else begin
        nextAddrPend = d[11];
        if (op == 1) begin mOvPend = 1; mTgt = code; end
        else if (op == 2 && code <= 4) begin mSrc = code; mSrcWord = d; mSegIdx = segStart; end
        else if (op == 3 && code <= 5) begin mDst = code; mDstWord = d; mSegIdx = segStart; end
      end
    end
    if (sel && isCmd && !isWr) begin
      if (mOvPend) begin
        mOvPend = 0;
        case (mTgt)
          0: expData = mAddr;
          1: expData = mCtrl;
          2: expData = mPage;
          3: expData = mSeg;
          4: expData = mDevSel;
          5: expData = {12'h0, freeAddr};
          6: expData = mSrcWord;
          default: expData = mDstWord;
        endcase
      end else begin
        expData = mStatHi ? statusIn[31:16] : statusIn[15:0];
        nextStatHi = !mStatHi;
      end
    end
    if (sel && isData) begin
      // kind: 0 comp, 1 mask1, 2 mask2, 3 array
      kind = isWr ? mDst : mSrc;
      entry = mAddr[3:0];
      if (isWr && kind == 4) entry = freeAddr;
      if ((isWr && kind == 5) || (!isWr && kind == 4)) entry = matchAddr;
      if (kind > 3) kind = 3;
      if (isWr) begin
        case (kind)
          0: mComp[mSegIdx] = d;
          1: mM1[mSegIdx] = d;
          2: mM2[mSegIdx] = d;
          default: mArr[entry][mSegIdx] = d;
        endcase
      end else begin
        case (kind)
          0: expData = mComp[mSegIdx];
          1: expData = mM1[mSegIdx];
          2: expData = mM2[mSegIdx];
          default: expData = mArr[entry][mSegIdx];
        endcase
      end
      mSegIdx = (mSegIdx == segEnd) ? segStart : (mSegIdx + 1) % 4;
    end
    mAddrPend = nextAddrPend;
    mStatHi = nextStatHi;
  endtask

  task automatic cyc(input bit en, input bit cm, input bit w, input logic [15:0] d, input string tag);
    bit expOe;
    logic [15:0] expData;
    @(negedge clk);
    enN = en; cmN = cm; wN = w; dataIn = d;
    #1;
    modelCycle(en, cm, w, d, expOe, expData);
    checks++;
    if (dataOe !== expOe || (expOe && dataOut !== expData)) begin
      errors++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", tag, dataOe, dataOut, expOe, expData);
    end
  endtask

  task automatic idle(input string tag);      cyc(1, 1, 1, 16'h0, tag); endtask
  task automatic cmdW(input logic [15:0] d, input string tag); cyc(0, 0, 0, d, tag); endtask
  task automatic cmdR(input string tag);      cyc(0, 0, 1, 16'h0, tag); endtask
  task automatic datW(input logic [15:0] d, input string tag); cyc(0, 1, 0, d, tag); endtask
  task automatic datR(input string tag);      cyc(0, 1, 1, 16'h0, tag); endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL R1: watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // reset state
    idle("R1");
    datR("R7"); datR("R7");
    // status alternation
    cmdR("R6"); cmdR("R6"); cmdR("R6");
    idle("R6"); cmdR("R6"); cmdR("R6");
    datR("R6"); cmdR("R6");
    // comparand words with wrap
    for (int i = 0; i < 5; i++) datW(16'hC000 + 16'(i), "R10");
    for (int i = 0; i < 4; i++) datR("R10");
    // mask 1 as source and destination
    cmdW(16'h3001, "R7"); cmdW(16'h2001, "R7");
    for (int i = 0; i < 4; i++) datW(16'h1100 + 16'(i), "R7");
    for (int i = 0; i < 4; i++) datR("R7");
    cmdW(16'h3002, "R7");
    datW(16'h2222, "R7");
    cmdW(16'h2002, "R7"); datR("R7");
    cmdW(16'h2007, "R7"); datR("R7");
    cmdW(16'h2000, "R7"); datR("R7"); datR("R7");
    // override one-shot
    cmdW(16'h1001, "R4"); cmdW(16'hA5A5, "R4");
    cmdW(16'h0000, "R2");
    cmdW(16'h1001, "R4"); cmdR("R4"); cmdR("R4");
    cmdW(16'h1001, "R4"); datR("R4"); idle("R4"); cmdR("R4");
    // address flag
    cmdW(16'h0800, "R3"); cmdW(16'h0005, "R3");
    cmdW(16'h1000, "R3"); cmdR("R3");
    cmdW(16'h0800, "R3"); idle("R3"); cmdW(16'h0007, "R3");
    cmdW(16'h1000, "R3"); cmdR("R3");
    // next-free address
    cmdW(16'h1005, "R5"); cmdR("R5");
    cmdW(16'h1005, "R5"); cmdW(16'h0003, "R5");
    cmdW(16'h1005, "R5"); cmdR("R5");
    cmdW(16'h1000, "R5"); cmdR("R5");
    // selection words
    cmdW(16'h1006, "R9"); cmdR("R9");
    cmdW(16'h1007, "R9"); cmdR("R9");
    // narrowed segment window
    cmdW(16'h1003, "R10"); cmdW(16'h0009, "R10");
    cmdW(16'h1003, "R10"); cmdR("R10");
    for (int i = 0; i < 3; i++) datW(16'hD000 + 16'(i), "R10");
    cmdW(16'h3000, "R10"); datW(16'hD100, "R10");
    cmdW(16'h2000, "R10");
    for (int i = 0; i < 3; i++) datR("R10");
    cmdW(16'h1003, "R10"); cmdW(16'h000C, "R10");
    // array modes
    cmdW(16'h3003, "R11");
    for (int i = 0; i < 4; i++) datW(16'h5A00 + 16'(i), "R11");
    cmdW(16'h2004, "R11");
    for (int i = 0; i < 4; i++) datR("R11");
    cmdW(16'h3004, "R11");
    for (int i = 0; i < 4; i++) datW(16'h9B00 + 16'(i), "R11");
    cmdW(16'h3005, "R11"); datW(16'h7777, "R11");
    cmdW(16'h0800, "R11"); cmdW(16'h0009, "R11");
    cmdW(16'h2003, "R11");
    for (int i = 0; i < 4; i++) datR("R11");
    cmdW(16'h2004, "R11"); datR("R11");
    // broadcast and deselection
    cmdW(16'h3000, "R8");
    cmdW(16'h1004, "R8"); cmdW(16'hFFFF, "R8");
    cmdR("R8"); datR("R8"); datW(16'hEE00, "R8");
    cmdW(16'h1002, "R8"); cmdW(16'h0002, "R8");
    cmdW(16'h1004, "R8"); cmdW(16'h0003, "R8");
    cmdR("R8"); datR("R8"); datW(16'hEE01, "R8");
    cmdW(16'h1001, "R8"); cmdR("R8");
    cmdW(16'h1004, "R8"); cmdW(16'h0002, "R8");
    cmdR("R8"); cmdR("R8");
    cmdW(16'h2000, "R8");
    for (int i = 0; i < 4; i++) datR("R8");
    cmdW(16'h1001, "R1"); cmdR("R1");
    idle("R1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule